// File: doc/BRIEF.md
# Scroll and VRAM Address Register Port

This block is the processor-side register window of a tile-based video controller. A host issues byte-wide reads and writes to eight register slots. From those writes it assembles a 15-bit temporary address, a 15-bit current video-memory address and a 3-bit fine horizontal scroll. One write toggle is shared by the scroll slot and the address slot, so each of them takes two consecutive writes to fill in a complete word.

The data slot turns host accesses into video-memory traffic. Addresses below 0x2000 go to external pattern memory. Pattern reads pass through a one-deep buffer, so each read returns the byte fetched by the read before it. Addresses from 0x2000 up to 0x3EFF go to an external 2 KB nametable memory, with the page bit taken from the mirroring input. Addresses from 0x3F00 upward go to a 32-entry palette held inside the block, in which four background entries are shared with the sprite side. After every data access the current address moves on by 1 or by 32.

A status slot reports three flags. Other blocks set and clear these flags through single-cycle strobes. Reading the status slot also restarts the two-write sequence.

Top module: `scroll_addr_port`

## Requirements
- R1: A synchronous reset clears the current address, the temporary address, fine X, the write toggle, the control register, the read buffer, the palette, the status flags and the read data.
- R2: A write to slot 0 stores the control byte and copies data bits 1:0 into temporary-address bits 11:10.
- R3: A scroll write (slot 5) with the toggle clear loads fine X from data bits 2:0 and temporary bits 4:0 from data bits 7:3, then sets the toggle. With the toggle set, it loads temporary bits 14:12 from data bits 2:0 and bits 9:5 from data bits 7:3, then clears the toggle.
- R4: An address write (slot 6) with the toggle clear puts data bits 5:0 into temporary bits 13:8 and clears bit 14, leaving the current address unchanged. With the toggle set, it replaces temporary bits 7:0 and copies the resulting temporary address into the current address.
- R5: A status read (slot 2) returns {vblank, hit, overflow, 5'b0} in bit order 7 to 5. It then clears the vblank flag and the write toggle.
- R6: Every data-slot access (slot 7, read or write) adds 32 to the 15-bit current address when control bit 2 is 1, and adds 1 when it is 0.
- R7: Palette accesses use current-address bits 4:0. Indices 0x10, 0x14, 0x18 and 0x1C refer to the same entries as 0x00, 0x04, 0x08 and 0x0C.
- R8: Nametable accesses drive nt_addr = {page, addr[9:0]}. The page bit is address bit 10 when mirror_horiz is 0, and address bit 11 when mirror_horiz is 1. Nametable reads return nt_rdata without delay.
- R9: A data read with a 14-bit address below 0x2000 returns the previously buffered byte and refills the buffer from pat_rdata.
- R10: Writes to slots 1, 2, 3 and 4 leave the current address, the temporary address and fine X unchanged.
- R11: vbl_set, hit_set and ovf_set each set their own flag, and flags_clr clears all three. A set in the same cycle as a clear or a status read wins. That read still returns the flag values from before the set.
- R12: Read data is registered: bus_rdata takes the read value on the clock edge that ends the read cycle. Reads of slots other than 2 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_reg | input | 3 | Register slot |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| mirror_horiz | input | 1 | 0: address bit 10 picks the nametable page; 1: address bit 11 picks it |
| vbl_set | input | 1 | Sets the vblank flag |
| hit_set | input | 1 | Sets the hit flag |
| ovf_set | input | 1 | Sets the overflow flag |
| flags_clr | input | 1 | Clears all three flags |
| ctrl_out | output | 8 | Control register |
| cur_addr | output | 15 | Current video-memory address |
| tmp_addr | output | 15 | Temporary address |
| fine_x | output | 3 | Fine horizontal scroll |
| pat_addr | output | 13 | Pattern memory address |
| pat_we | output | 1 | Pattern memory write strobe |
| pat_rdata | input | 8 | Pattern memory read data, combinational |
| nt_addr | output | 11 | Folded nametable address |
| nt_we | output | 1 | Nametable write strobe |
| nt_rdata | input | 8 | Nametable read data, combinational |
| mem_wdata | output | 8 | Write data for the external memories |

## Verification
The hardest case to reach is the write toggle left half-way through a sequence. A lone address write must be followed by a status read, and only then does the next pair of address writes produce a clean address. The bench leaves the toggle set on purpose, reads the status slot, and then checks that the next two writes land as a first write and a second write. A second hard case is a flag set arriving in the very cycle of a status read. The bench drives vbl_set and the read strobe on the same edge, then expects the old value on the bus and the flag still set on the following read.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int DW   = 8;
  localparam int VW   = 15;
  localparam int MW   = VW - 1;
  localparam int NTW  = 11;
  localparam int PTW  = 13;
  localparam int PALW = 5;

  typedef enum logic [2:0] {
    RG_CONTROL = 3'd0,
    RG_DISPLAY = 3'd1,
    RG_FLAGS   = 3'd2,
    RG_OBJPTR  = 3'd3,
    RG_OBJDAT  = 3'd4,
    RG_SCROLL  = 3'd5,
    RG_VADDR   = 3'd6,
    RG_PORT    = 3'd7
  } reg_slot_e;

  typedef enum logic [1:0] {
    TGT_PATTERN   = 2'd0,
    TGT_NAMETABLE = 2'd1,
    TGT_PALETTE   = 2'd2
  } tgt_e;

  function automatic tgt_e target_of(input logic [MW-1:0] a);
    if (a < 14'h2000)      return TGT_PATTERN;
    else if (a < 14'h3F00) return TGT_NAMETABLE;
    else                   return TGT_PALETTE;
  endfunction

  function automatic logic [PALW-1:0] pal_fold(input logic [PALW-1:0] i);
    return (i[4] && i[1:0] == 2'b00) ? {1'b0, i[3:0]} : i;
  endfunction

  function automatic logic [NTW-1:0] nt_fold(input logic [MW-1:0] a, input logic horiz);
    return {(horiz ? a[11] : a[10]), a[9:0]};
  endfunction

  function automatic logic [VW-1:0] addr_step(input logic [VW-1:0] a, input logic wide);
    return a + (wide ? VW'(32) : VW'(1));
  endfunction
endpackage

// File: rtl/sap_addr_regs.sv
module sap_addr_regs
  import sap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_scroll,
  input  logic          wr_addr,
  input  logic          data_acc,
  input  logic          status_rd,
  input  logic          incr32,
  input  logic [DW-1:0] wdata,
  output logic [VW-1:0] tmp,
  output logic [VW-1:0] cur,
  output logic [2:0]    fine,
  output logic          toggle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tmp    <= '0;
      cur    <= '0;
      fine   <= '0;
      toggle <= 1'b0;
    end else begin
      if (status_rd) toggle <= 1'b0;
      if (wr_ctrl) tmp[11:10] <= wdata[1:0];
      if (wr_scroll) begin
        if (!toggle) begin
          fine     <= wdata[2:0];
          tmp[4:0] <= wdata[7:3];
          toggle   <= 1'b1;
        end else begin
          tmp[14:12] <= wdata[2:0];
          tmp[9:5]   <= wdata[7:3];
          toggle     <= 1'b0;
        end
      end
      if (wr_addr) begin
        if (!toggle) begin
          tmp[13:8] <= wdata[5:0];
          tmp[14]   <= 1'b0;
          toggle    <= 1'b1;
        end else begin
          tmp[7:0] <= wdata;
          cur      <= {tmp[14:8], wdata};
          toggle   <= 1'b0;
        end
      end
      if (data_acc) cur <= addr_step(cur, incr32);
    end
  end

  p_ctrl_page_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> tmp[11:10] == $past(wdata[1:0]));
  p_scroll_first_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_scroll && !toggle) |=> (fine == $past(wdata[2:0]) && toggle));
  p_scroll_second_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_scroll && toggle) |=> (tmp[14:12] == $past(wdata[2:0]) && !toggle));
  p_addr_high_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_addr && !toggle) |=> (!tmp[14] && $stable(cur)));
  p_addr_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_addr && toggle) |=> cur == tmp);
  p_toggle_reset_r5: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> !toggle);
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> cur == $past(cur) + ($past(incr32) ? VW'(32) : VW'(1)));
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !(wr_ctrl || wr_scroll || wr_addr || data_acc) |=> ($stable(tmp) && $stable(cur) && $stable(fine)));
endmodule

// File: rtl/sap_mem_route.sv
module sap_mem_route
  import sap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [MW-1:0]   vaddr,
  input  logic            horiz,
  output tgt_e            tgt,
  output logic [NTW-1:0]  nt_addr,
  output logic [PTW-1:0]  pat_addr,
  output logic [PALW-1:0] pal_idx
);
  always_comb begin
    tgt      = target_of(vaddr);
    nt_addr  = nt_fold(vaddr, horiz);
    pat_addr = vaddr[PTW-1:0];
    pal_idx  = pal_fold(vaddr[PALW-1:0]);
  end

  p_alias_r7: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_PALETTE && pal_idx[4]) |-> pal_idx[1:0] != 2'b00);
  p_mirror_v_r8: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_NAMETABLE && !horiz) |-> nt_addr[10] == vaddr[10]);
  p_mirror_h_r8: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_NAMETABLE && horiz) |-> nt_addr[10] == vaddr[11]);
endmodule

// File: rtl/sap_palette.sv
module sap_palette
  import sap_pkg::*;
#(
  parameter int IW = PALW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << IW;
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/scroll_addr_port.sv
module scroll_addr_port
  import sap_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [2:0]     bus_reg,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           mirror_horiz,
  input  logic           vbl_set,
  input  logic           hit_set,
  input  logic           ovf_set,
  input  logic           flags_clr,
  output logic [DW-1:0]  ctrl_out,
  output logic [VW-1:0]  cur_addr,
  output logic [VW-1:0]  tmp_addr,
  output logic [2:0]     fine_x,
  output logic [PTW-1:0] pat_addr,
  output logic           pat_we,
  input  logic [DW-1:0]  pat_rdata,
  output logic [NTW-1:0] nt_addr,
  output logic           nt_we,
  input  logic [DW-1:0]  nt_rdata,
  output logic [DW-1:0]  mem_wdata
);
  logic [DW-1:0]   ctrl_q, buf_q, rdata_q, pal_rd, rd_val;
  logic            vbl_q, hit_q, ovf_q, toggle;
  logic            wr_ctrl, wr_scroll, wr_addr, data_acc, data_rd, data_wr, stat_rd, pal_we;
  tgt_e            tgt;
  logic [PALW-1:0] pal_idx;

  // decoded host events
  assign wr_ctrl   = bus_sel && bus_wr && bus_reg == RG_CONTROL;
  assign wr_scroll = bus_sel && bus_wr && bus_reg == RG_SCROLL;
  assign wr_addr   = bus_sel && bus_wr && bus_reg == RG_VADDR;
  assign data_acc  = bus_sel && bus_reg == RG_PORT;
  assign data_wr   = data_acc && bus_wr;
  assign data_rd   = data_acc && !bus_wr;
  assign stat_rd   = bus_sel && !bus_wr && bus_reg == RG_FLAGS;

  sap_addr_regs u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_scroll(wr_scroll), .wr_addr(wr_addr),
    .data_acc(data_acc), .status_rd(stat_rd), .incr32(ctrl_q[2]), .wdata(bus_wdata),
    .tmp(tmp_addr), .cur(cur_addr), .fine(fine_x), .toggle(toggle)
  );

  sap_mem_route u_route (
    .clk(clk), .rst(rst), .vaddr(cur_addr[MW-1:0]), .horiz(mirror_horiz),
    .tgt(tgt), .nt_addr(nt_addr), .pat_addr(pat_addr), .pal_idx(pal_idx)
  );

  assign pal_we = data_wr && tgt == TGT_PALETTE;

  sap_palette u_pal (
    .clk(clk), .rst(rst), .we(pal_we), .idx(pal_idx), .wdata(bus_wdata), .rdata(pal_rd)
  );

  assign pat_we    = data_wr && tgt == TGT_PATTERN;
  assign nt_we     = data_wr && tgt == TGT_NAMETABLE;
  assign mem_wdata = bus_wdata;

  always_comb begin
    rd_val = '0;
    if (bus_reg == RG_FLAGS) rd_val = {vbl_q, hit_q, ovf_q, 5'b0};
    else if (bus_reg == RG_PORT) begin
      case (tgt)
        TGT_PATTERN:   rd_val = buf_q;
        TGT_NAMETABLE: rd_val = nt_rdata;
        default:       rd_val = pal_rd;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      buf_q   <= '0;
      rdata_q <= '0;
      vbl_q   <= 1'b0;
      hit_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (bus_sel && !bus_wr) rdata_q <= rd_val;
      if (data_rd && tgt == TGT_PATTERN) buf_q <= pat_rdata;
      if (vbl_set) vbl_q <= 1'b1;
      else if (flags_clr || stat_rd) vbl_q <= 1'b0;
      if (hit_set) hit_q <= 1'b1;
      else if (flags_clr) hit_q <= 1'b0;
      if (ovf_set) ovf_q <= 1'b1;
      else if (flags_clr) ovf_q <= 1'b0;
    end
  end

  assign ctrl_out  = ctrl_q;
  assign bus_rdata = rdata_q;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && tmp_addr == '0 && fine_x == '0 && bus_rdata == '0 && !toggle));
  p_stat_read_r5: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> bus_rdata[7] == $past(vbl_q));
  p_vbl_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !vbl_set) |=> !vbl_q);
  p_buffer_delay_r9: assert property (@(posedge clk) disable iff (rst)
    (data_rd && tgt == TGT_PATTERN) |=> bus_rdata == $past(buf_q));
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (vbl_set || hit_set || ovf_set) |=> ((vbl_q || !$past(vbl_set)) && (hit_q || !$past(hit_set)) && (ovf_q || !$past(ovf_set))));
  p_write_no_data_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/scroll_addr_port_tb.sv
module scroll_addr_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [2:0]  bus_reg = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        mirror_horiz = 0, vbl_set = 0, hit_set = 0, ovf_set = 0, flags_clr = 0;
  logic [7:0]  ctrl_out;
  logic [14:0] cur_addr, tmp_addr;
  logic [2:0]  fine_x;
  logic [12:0] pat_addr;
  logic        pat_we, nt_we;
  logic [7:0]  pat_rdata, nt_rdata, mem_wdata;
  logic [10:0] nt_addr;
  logic [7:0]  nt_mem [2048];

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [7:0] exp_buf = 8'h00;
  logic done = 1'b0;

  always #2 clk = ~clk;

  scroll_addr_port u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mirror_horiz(mirror_horiz),
    .vbl_set(vbl_set), .hit_set(hit_set), .ovf_set(ovf_set), .flags_clr(flags_clr),
    .ctrl_out(ctrl_out), .cur_addr(cur_addr), .tmp_addr(tmp_addr), .fine_x(fine_x),
    .pat_addr(pat_addr), .pat_we(pat_we), .pat_rdata(pat_rdata), .nt_addr(nt_addr),
    .nt_we(nt_we), .nt_rdata(nt_rdata), .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] pat_model(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
  endfunction

  assign pat_rdata = pat_model(pat_addr);
  assign nt_rdata  = nt_mem[nt_addr];
  always @(posedge clk) if (nt_we) nt_mem[nt_addr] <= mem_wdata;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_reg = r; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] r, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_reg = r;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic set_addr(input logic [13:0] a);
    wr(3'd6, {2'b00, a[13:8]});
    wr(3'd6, a[7:0]);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: vbl_set = 1; 1: hit_set = 1; 2: ovf_set = 1; default: flags_clr = 1;
    endcase
    @(negedge clk); vbl_set = 0; hit_set = 0; ovf_set = 0; flags_clr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cur", 16'(cur_addr), 16'h0);
    chk("R1 tmp", 16'(tmp_addr), 16'h0);
    chk("R1 finex", 16'(fine_x), 16'h0);
    chk("R1 rdata", 16'(bus_rdata), 16'h0);
    rd(3'd2, d);
    chk("R1 flags", 16'(d), 16'h0);
  endtask

  task automatic t_ctrl();
    wr(3'd0, 8'h03);
    chk("R2 page bits", 16'(tmp_addr), 16'h0C00);
    chk("R2 ctrl", 16'(ctrl_out), 16'h03);
    wr(3'd0, 8'h00);
    chk("R2 page clear", 16'(tmp_addr), 16'h0000);
  endtask

  task automatic t_scroll();
    logic [7:0] a = 8'h7D, b = 8'h5E;
    logic [14:0] e;
    wr(3'd5, a);
    chk("R3 finex", 16'(fine_x), 16'(a & 8'h07));
    chk("R3 coarse x", 16'(tmp_addr), 16'(a >> 3));
    wr(3'd5, b);
    e = 15'(a >> 3) | (15'(b & 8'h07) << 12) | (15'(b >> 3) << 5);
    chk("R3 second", 16'(tmp_addr), 16'(e));
    chk("R3 finex kept", 16'(fine_x), 16'h5);
  endtask

  task automatic t_addr();
    wr(3'd6, 8'hFF);
    chk("R4 high byte", 16'(tmp_addr), 16'h3F6F);
    chk("R4 cur held", 16'(cur_addr), 16'h0000);
    wr(3'd6, 8'h12);
    chk("R4 tmp", 16'(tmp_addr), 16'h3F12);
    chk("R4 cur load", 16'(cur_addr), 16'h3F12);
  endtask

  task automatic t_status();
    logic [7:0] d;
    pulse(0);
    rd(3'd2, d);
    chk("R5 vblank read", 16'(d), 16'h80);
    rd(3'd2, d);
    chk("R5 vblank cleared", 16'(d), 16'h00);
    wr(3'd6, 8'h21);
    rd(3'd2, d);
    wr(3'd6, 8'h23);
    wr(3'd6, 8'h45);
    chk("R5 toggle restart", 16'(cur_addr), 16'h2345);
  endtask

  task automatic t_step();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    set_addr(14'h2000);
    wr(3'd7, 8'h11);
    chk("R6 step 1", 16'(cur_addr), 16'h2001);
    wr(3'd0, 8'h04);
    rd(3'd7, d);
    chk("R6 step 32", 16'(cur_addr), 16'h2021);
    set_addr(14'h3FFF);
    wr(3'd7, 8'h00);
    chk("R6 15-bit carry", 16'(cur_addr), 16'h401F);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_mirror();
    logic [7:0] d;
    mirror_horiz = 0;
    set_addr(14'h2400); wr(3'd7, 8'hA1);
    chk("R8 vertical write", 16'(nt_mem[11'h400]), 16'hA1);
    set_addr(14'h2C00); rd(3'd7, d);
    chk("R8 vertical read", 16'(d), 16'hA1);
    mirror_horiz = 1;
    set_addr(14'h2800); wr(3'd7, 8'hB2);
    chk("R8 horizontal write", 16'(nt_mem[11'h400]), 16'hB2);
    set_addr(14'h2C00); rd(3'd7, d);
    chk("R8 horizontal read", 16'(d), 16'hB2);
    set_addr(14'h2400); wr(3'd7, 8'hC3);
    chk("R8 horizontal low page", 16'(nt_mem[11'h000]), 16'hC3);
    set_addr(14'h3400); rd(3'd7, d);
    chk("R8 upper window", 16'(d), 16'hC3);
    mirror_horiz = 0;
  endtask

  task automatic t_palette();
    logic [7:0] d;
    set_addr(14'h3F10); wr(3'd7, 8'h2A);
    set_addr(14'h3F00); rd(3'd7, d);
    chk("R7 alias 10->00", 16'(d), 16'h2A);
    set_addr(14'h3F04); wr(3'd7, 8'h15);
    set_addr(14'h3F14); rd(3'd7, d);
    chk("R7 alias 14->04", 16'(d), 16'h15);
    set_addr(14'h3F11); wr(3'd7, 8'h33);
    set_addr(14'h3F01); rd(3'd7, d);
    chk("R7 no alias 11", 16'(d), 16'h00);
    set_addr(14'h3F31); rd(3'd7, d);
    chk("R7 five bits", 16'(d), 16'h33);
  endtask

  task automatic t_buffer();
    logic [7:0] d;
    set_addr(14'h0010);
    rd(3'd7, d);
    chk("R9 stale byte", 16'(d), 16'(exp_buf));
    exp_buf = pat_model(13'h0010);
    rd(3'd7, d);
    chk("R9 first fetch", 16'(d), 16'(exp_buf));
    exp_buf = pat_model(13'h0011);
    rd(3'd7, d);
    chk("R9 second fetch", 16'(d), 16'(exp_buf));
  endtask

  task automatic t_ignored();
    logic [14:0] t0, c0;
    logic [2:0]  f0;
    logic [7:0]  d;
    t0 = tmp_addr; c0 = cur_addr; f0 = fine_x;
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    chk("R10 tmp", 16'(tmp_addr), 16'(t0));
    chk("R10 cur", 16'(cur_addr), 16'(c0));
    chk("R10 finex", 16'(fine_x), 16'(f0));
    rd(3'd1, d);
    chk("R12 unused slot read", 16'(d), 16'h00);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    pulse(1); pulse(2);
    rd(3'd2, d);
    chk("R11 hit+ovf", 16'(d), 16'h60);
    pulse(3);
    rd(3'd2, d);
    chk("R11 clear", 16'(d), 16'h00);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_reg = 3'd2; vbl_set = 1;
    @(negedge clk); bus_sel = 0; vbl_set = 0; d = bus_rdata;
    chk("R11 read sees old", 16'(d), 16'h00);
    rd(3'd2, d);
    chk("R11 set wins", 16'(d), 16'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_scroll();
    t_addr();
    t_status();
    t_step();
    t_mirror();
    t_palette();
    t_buffer();
    t_ignored();
    t_flags();
    done = 1;
    summary();
  end
endmodule